// File: doc/BRIEF.md
# Delta Prefix-Code Sample Compressor

This block shrinks a continuous multichannel stream of detector samples before it reaches the frame buffer. Samples arrive two per beat, with the channels interleaved in a fixed rotation. For every channel the block keeps the last sample it saw and codes only the step from that sample to the new one. The signed step is folded onto a non-negative index, so that small steps of either sign get short codes. The index is then sent as a run of zeros closed by a one. Rare large steps escape to the raw sample.

The code bits of both lanes are joined in time order and packed MSB-first into a bit accumulator, which releases fixed-width output words. A frame-start marker restarts the channel rotation and the predictors: the first pass through the channels in each frame sends each sample raw behind a marker bit. A frame-end marker makes the block drain the accumulator, pad the final word with zeros and flag that word as last. A stall input freezes both the input acceptance and the output for as long as it is held, and no bits are lost.

Top module: `delta_code_packer`

## Requirements
- R1: In the first pass of a frame, which covers channels 0 to NCH-1 and starts with the beat flagged by `in_first`, each sample is coded as a one bit followed by its 12 sample bits, MSB first.
- R2: Every later sample is coded from d = current minus previous sample of the same channel. d = 0 gives index 0, d > 0 gives index 2d-1 and d < 0 gives index -2d.
- R3: An index k from 0 to 14 is sent as k zero bits followed by a single one bit.
- R4: An index of 15 or more is sent as 15 zero bits followed by the 12-bit current sample, MSB first.
- R5: On each beat, `in_s0` belongs to channel c and `in_s1` to channel c+1. Its code comes first in the bit stream. The first beat of a frame has c = 0, and c advances by 2 on every accepted beat, modulo NCH.
- R6: The code bits are packed MSB-first and without gaps into 32-bit words, carried across beat boundaries. A word is presented on `out_data` in the cycle `out_valid` is high and is consumed in that cycle.
- R7: After a beat carrying `in_end` has been accepted, all remaining bits of the frame are sent. The final word is padded with zero bits in its low positions. `out_last` is high with that word and with no other word.
- R8: While `stall` is high, `out_valid` and `in_ready` are both low and the block's stored state does not change. Once `stall` falls, the output continues with the bits that were pending.
- R9: `in_ready` is low from the cycle after an end beat is accepted until the last word of that frame has been sent. An input beat counts as accepted only in a cycle where `in_valid` and `in_ready` are both high.
- R10: A frame start restarts the prediction. Samples from an earlier frame never serve as the previous value in a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Freeze input acceptance and output |
| in_valid | input | 1 | Beat present on the input |
| in_ready | output | 1 | Block can accept the beat this cycle |
| in_first | input | 1 | Beat is the first of a frame |
| in_end | input | 1 | Beat is the last of a frame |
| in_s0 | input | SW | Sample of channel c |
| in_s1 | input | SW | Sample of channel c+1 |
| out_valid | output | 1 | Word presented and taken this cycle |
| out_data | output | OW | Packed code word, first bit in the MSB |
| out_last | output | 1 | Final, zero-padded word of a frame |

## Verification
The assertions assume that the source holds a beat steady until it is accepted, and that frames are well formed: every frame opens with an `in_first` beat and closes with an `in_end` beat, which may be the same beat. They also assume that the number of channels is an even power of two. The stimulus builds every frame from whole beats, begins each one with `in_first`, and repeats a refused beat unchanged. It sweeps the steps from -20 to +20 across the unary and escape boundary, steps the full range from 0 to 4095, sends a frame of one beat, and runs a frame with random stalls and input gaps.

// File: rtl/delta_code_packer.sv
module delta_code_packer #(
  parameter int NCH = 64,
  parameter int SW  = 12,
  parameter int OW  = 32,
  parameter int ESC = 15,
  parameter int ACC = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_first,
  input  logic          in_end,
  input  logic [SW-1:0] in_s0,
  input  logic [SW-1:0] in_s1,
  output logic          out_valid,
  output logic [OW-1:0] out_data,
  output logic          out_last
);
  localparam int CW   = $clog2(NCH);
  localparam int DW   = SW + 1;
  localparam int MAXC = ESC + SW;
  localparam int PW   = 2 * MAXC;
  localparam int FW   = $clog2(ACC + 1);
  localparam int SHW  = FW + 1;
  localparam int LW   = $clog2(PW + 1);

  logic [SW-1:0]  prev_q [NCH];
  logic [CW-1:0]  chan_q;
  logic           rawph_q, flush_q;
  logic [ACC-1:0] acc_q;
  logic [FW-1:0]  fill_q;

  function automatic logic [LW+MAXC-1:0] enc(input logic raw, input logic [SW-1:0] cur,
                                              input logic [SW-1:0] prv);
    logic signed [DW-1:0] d;
    logic [DW-1:0] n, k;
    logic [LW-1:0] len;
    logic [MAXC-1:0] val;
    d = $signed({1'b0, cur}) - $signed({1'b0, prv});
    n = -d;
    if (d == 0)     k = '0;
    else if (d > 0) k = {d[DW-2:0], 1'b0} - DW'(1);
    else            k = {n[DW-2:0], 1'b0};
    if (raw) begin
      len = LW'(SW + 1);
      val = MAXC'({1'b1, cur});
    end else if (k < DW'(ESC)) begin
      len = LW'(k) + LW'(1);
      val = MAXC'(1);
    end else begin
      len = LW'(MAXC);
      val = MAXC'(cur);
    end
    return {len, val};
  endfunction

  logic [CW-1:0] base;
  logic          raw, take, pop;
  logic [LW+MAXC-1:0] c0, c1;
  logic [LW-1:0] lenp;
  logic [PW-1:0] pair;
  logic [ACC-1:0] a_pop, al, acc_d;
  logic [FW-1:0] f_pop, fill_d;

  assign base      = in_first ? '0 : chan_q;
  assign raw       = in_first | rawph_q;
  assign in_ready  = !stall && !flush_q && (fill_q <= FW'(ACC - PW));
  assign take      = in_valid && in_ready;
  assign out_valid = !stall && ((fill_q >= FW'(OW)) || (flush_q && fill_q != '0));
  assign out_last  = out_valid && flush_q && (fill_q <= FW'(OW));
  assign out_data  = acc_q[ACC-1 -: OW];
  assign pop       = out_valid;

  assign c0   = enc(raw, in_s0, prev_q[base]);
  assign c1   = enc(raw, in_s1, prev_q[base + CW'(1)]);
  assign lenp = c0[LW+MAXC-1 -: LW] + c1[LW+MAXC-1 -: LW];
  assign pair = (PW'(c0[MAXC-1:0]) << c1[LW+MAXC-1 -: LW]) | PW'(c1[MAXC-1:0]);

  always_comb begin
    a_pop  = pop ? (acc_q << OW) : acc_q;
    f_pop  = pop ? ((fill_q > FW'(OW)) ? fill_q - FW'(OW) : '0) : fill_q;
    al     = (ACC'(pair) << (SHW'(ACC) - SHW'(lenp))) >> f_pop;
    acc_d  = take ? (a_pop | al) : a_pop;
    fill_d = take ? f_pop + FW'(lenp) : f_pop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q  <= '0;
      rawph_q <= 1'b0;
      flush_q <= 1'b0;
      acc_q   <= '0;
      fill_q  <= '0;
    end else begin
      acc_q  <= acc_d;
      fill_q <= fill_d;
      if (take) begin
        chan_q  <= base + CW'(2);
        rawph_q <= raw && (base != CW'(NCH - 2));
        if (in_end) flush_q <= 1'b1;
      end else if (out_last) begin
        flush_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      prev_q[base]           <= in_s0;
      prev_q[base + CW'(1)]  <= in_s1;
    end
  end
endmodule

// File: rtl/delta_code_packer_chk.sv
module delta_code_packer_chk #(
  parameter int ACC = 128,
  parameter int OW  = 32,
  parameter int FW  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          stall,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_end,
  input logic          out_valid,
  input logic          out_last,
  input logic [OW-1:0] out_data,
  input logic          flush,
  input logic [FW-1:0] fill
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (fill == $past(fill)) && (out_data == $past(out_data)) && (flush == $past(flush)));

  // R6
  fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(ACC));

  // R7
  last_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> (fill == '0) && !flush);

  // R7
  flush_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flush) |-> $past(out_last));

  // R9
  end_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_end) |=> !in_ready);
endmodule

bind delta_code_packer delta_code_packer_chk #(.ACC(ACC), .OW(OW), .FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .in_valid(in_valid), .in_ready(in_ready),
  .in_end(in_end), .out_valid(out_valid), .out_last(out_last), .out_data(out_data),
  .flush(flush_q), .fill(fill_q)
);

// File: tb/sim_delta_code_packer.sv
module sim_delta_code_packer;
  localparam int CP  = 10;
  localparam int NCH = 4;
  localparam int SW  = 12;
  localparam int OW  = 32;

  logic clk = 1'b0, rst_n = 1'b0, stall = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_end = 1'b0;
  logic [SW-1:0] in_s0 = '0, in_s1 = '0;
  logic in_ready, out_valid, out_last;
  logic [OW-1:0] out_data;

  always #(CP/2) clk = ~clk;

  delta_code_packer #(.NCH(NCH), .SW(SW), .OW(OW)) u0 (
    .clk(clk), .rst_n(rst_n), .stall(stall), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_end(in_end), .in_s0(in_s0), .in_s1(in_s1),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last));

  int nchk = 0, nbad = 0;
  bit exp_q[$];
  bit exp_f[$];
  int prv[NCH];
  int mch = 0;
  bit mraw = 0;
  bit stall_en = 0, gap_en = 0;
  logic [15:0] lfsr = 16'hACE1;
  int cur[NCH];

  task automatic push_bits(input int val, input int len);
    for (int i = len - 1; i >= 0; i--) begin
      exp_q.push_back(val[i]);
      exp_f.push_back(1'b0);
    end
  endtask

  // R1 R2 R3 R4: code of one sample, computed from the requirements
  task automatic code_one(input bit raw, input int s, input int p);
    int d, k;
    if (raw) begin
      push_bits(1, 1);
      push_bits(s, SW);
    end else begin
      d = s - p;
      k = (d == 0) ? 0 : (d > 0 ? 2 * d - 1 : -2 * d);
      if (k < 15) begin
        push_bits(0, k);
        push_bits(1, 1);
      end else begin
        push_bits(0, 15);
        push_bits(s, SW);
      end
    end
  endtask

  // R5 R10: channel rotation and restart, R7: padding and last flag
  task automatic model(input bit f, input bit e, input int a, input int b);
    int ch;
    bit raw;
    ch  = f ? 0 : mch;
    raw = f || mraw;
    code_one(raw, a, prv[ch]);
    code_one(raw, b, prv[ch + 1]);
    prv[ch] = a;
    prv[ch + 1] = b;
    mch  = (ch + 2) % NCH;
    mraw = raw && (ch + 2 < NCH);
    if (e) begin
      while (exp_q.size() % OW != 0) begin
        exp_q.push_back(1'b0);
        exp_f.push_back(1'b0);
      end
      exp_f[exp_f.size() - 1] = 1'b1;
    end
  endtask

  task automatic check_out();
    logic [OW-1:0] w;
    bit l;
    if (out_valid) begin
      nchk++;
      if (exp_q.size() < OW) begin
        nbad++;
        $display("FAIL R6 unexpected word: actual=%h expected=none", out_data);
      end else begin
        for (int i = OW - 1; i >= 0; i--) begin
          w[i] = exp_q.pop_front();
          l = exp_f.pop_front();
        end
        // R1 R2 R3 R4 R5 R6 R10 via the word content
        if (out_data !== w) begin
          nbad++;
          $display("FAIL R6 word (R1/R2/R3/R4/R5/R10): actual=%h expected=%h", out_data, w);
        end
        nchk++;
        if (out_last !== l) begin
          nbad++;
          $display("FAIL R7 last flag: actual=%b expected=%b", out_last, l);
        end
      end
    end
  endtask

  task automatic tick(input bit v, input bit f, input bit e, input int a, input int b,
                      output bit took);
    @(negedge clk);
    in_valid = v; in_first = f; in_end = e;
    in_s0 = SW'(a); in_s1 = SW'(b);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    stall = stall_en && (lfsr[1:0] == 2'b00);
    #(CP/4);
    check_out();
    if (stall) begin
      nchk++;
      if (in_ready || out_valid) begin
        nbad++;
        $display("FAIL R8 stall: actual ready=%b valid=%b expected 0 0", in_ready, out_valid);
      end
    end
    took = v && in_ready;
    if (took) model(f, e, a, b);
  endtask

  task automatic send(input bit f, input bit e, input int a, input int b);
    bit took;
    bit dummy;
    if (gap_en && lfsr[3]) tick(0, 0, 0, 0, 0, dummy);
    took = 0;
    while (!took) tick(1, f, e, a, b, took);
  endtask

  task automatic send_round(input bit f, input bit e);
    for (int p = 0; p < NCH; p += 2)
      send(f && p == 0, e && p == NCH - 2, cur[p], cur[p + 1]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    bit dummy;
    int dl;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #(CP/4);
    nchk++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1 || out_last !== 1'b0) begin
      nbad++;
      $display("FAIL R6 reset: actual v=%b r=%b l=%b expected 0 1 0", out_valid, in_ready, out_last);
    end

    // Frame 1: step sweep -20..+20, opposite signs on odd channels (R2 R3 R4)
    for (int c = 0; c < NCH; c++) cur[c] = 1500 + 500 * c;
    send_round(1, 0);
    for (int r = 1; r <= 41; r++) begin
      for (int c = 0; c < NCH; c++) cur[c] += (c % 2 == 0) ? (r - 21) : (21 - r);
      send_round(0, r == 41);
    end

    // Frame 2: full-scale steps and restart of prediction (R10)
    for (int r = 0; r < 8; r++) begin
      cur[0] = (r % 2) ? 4095 : 0;
      cur[1] = (r % 2) ? 0 : 4095;
      cur[2] = 2048;
      cur[3] = 2047 + (r % 3);
      send_round(r == 0, r == 7);
    end

    // Frame 3: single beat that is both first and end (R1 R7)
    send(1, 1, 7, 4000);

    // Frame 4: random small steps with stalls and gaps (R8 R9)
    stall_en = 1; gap_en = 1;
    for (int c = 0; c < NCH; c++) cur[c] = 300 + 700 * c;
    for (int r = 0; r < 31; r++) begin
      if (r > 0)
        for (int c = 0; c < NCH; c++) begin
          dl = int'(lfsr[4:0]) % 19 - 9;
          cur[c] = cur[c] + dl;
          if (cur[c] < 0) cur[c] = 0;
          if (cur[c] > 4095) cur[c] = 4095;
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        end
      send_round(r == 0, r == 30);
    end

    // Frame 5: one full raw pass only (R1 R5)
    for (int c = 0; c < NCH; c++) cur[c] = 4095 - 37 * c;
    send_round(1, 1);

    stall_en = 0; gap_en = 0;
    for (int i = 0; i < 200 && exp_q.size() != 0; i++) tick(0, 0, 0, 0, 0, dummy);
    repeat (5) tick(0, 0, 0, 0, 0, dummy);
    nchk++;
    if (exp_q.size() != 0) begin
      nbad++;
      $display("FAIL R7 drain: actual pending=%0d expected=0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule